// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block is a programmable sum-of-products cell with no state. Eighteen input literals (a sixteen-bit general routing bus plus two dedicated pins) are each offered in true and inverted form to twenty product terms. A static configuration vector gives each term its literal masks and an enable bit. The terms fall into four OR groups of uneven size. A sharing stage forms the group sums and steers any union of them to each of four outputs.

Each output has one of four modes. Shared mode takes the selected group union. Bypass mode takes a fixed quartet of terms directly. XOR mode takes the shared union and also exports one fixed term as the second operand of an XOR that sits downstream. Single mode takes one fixed term. Two terms can instead be taken for control duties: a local clock, a local reset and a local output enable. When a term is taken this way it no longer feeds any sum. The outputs go to a register stage that lies outside this block. All configuration arrives on static input ports.

Top module: `ptl_logic_cell`

## Requirements
- R1: Literal index i is bus_in[i] for i in 0..15 and ded_in[i-16] for i in 16..17. Term t is the AND of every input whose bit cfg_true_mask[t*18+i] is set and the inverse of every input whose bit cfg_comp_mask[t*18+i] is set. A term that sets both bits for one input is always 0.
- R2: A term whose cfg_term_en bit is 0 evaluates to 0. An enabled term with no literals selected evaluates to 1. With all configuration at zero, every output is 0.
- R3: Group 0 holds terms 0..3, group 1 holds terms 4..7, group 2 holds terms 8..12 and group 3 holds terms 13..19. Each group sum is the OR of its member terms that are still available for logic.
- R4: cfg_out_mode[2k+:2] selects the mode of output k. In shared mode (code 0), sum_out[k] is the OR of the groups g whose bit cfg_grp_sel[4k+g] is set. Selecting several groups combines them (for example groups 1 and 3 give 11 terms). An empty selection gives 0. xor_b[k] is 0.
- R5: In bypass mode (code 1), sum_out[k] is the OR of terms 4k..4k+3 and the group selection is ignored. xor_b[k] is 0.
- R6: In XOR mode (code 2), sum_out[k] follows the shared-mode rule and xor_b[k] equals term 4k. Term 4k is then removed from every group sum.
- R7: In single mode (code 3), sum_out[k] equals term 4k and xor_b[k] is 0.
- R8: cfg_pt12_mode picks the use of term 12: 0 for logic, 1 for the local clock on pt_clk, 2 for reset on pt_rst. Any non-zero code removes term 12 from group and bypass sums.
- R9: cfg_pt19_mode picks the use of term 19: 0 for logic, 1 for the output enable on pt_oe, 2 for reset on pt_rst. Any non-zero code removes term 19 from the sums. pt_rst is the OR of both reset sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_in | input | 16 | General routing bus literals |
| ded_in | input | 2 | Dedicated pin literals |
| cfg_true_mask | input | 360 | Per-term true-literal selects, term-major |
| cfg_comp_mask | input | 360 | Per-term inverted-literal selects, term-major |
| cfg_term_en | input | 20 | Per-term enable |
| cfg_out_mode | input | 8 | Two-bit mode per output |
| cfg_grp_sel | input | 16 | Four group-select bits per output |
| cfg_pt12_mode | input | 2 | Use of term 12 |
| cfg_pt19_mode | input | 2 | Use of term 19 |
| sum_out | output | 4 | Output sums toward the register stage |
| xor_b | output | 4 | XOR second operand per output |
| pt_clk | output | 1 | Local product-term clock |
| pt_rst | output | 1 | Local product-term reset |
| pt_oe | output | 1 | Local product-term output enable |

## Verification
The bench builds the cell with its default parameters: a 16-bit bus, 2 dedicated pins, groups of 4, 4, 5 and 7 terms, control terms at 12 and 19, and the XOR variant present. With these values, term 12 sits at the last position of the five-term group and also inside output 3's bypass quartet and single term. Term 19 closes the seven-term group. As a result, taking a term for control, removing a term for XOR and combining groups can all be seen crossing group and mode boundaries on the outputs. One sweep enables each of the twenty terms on its own, which exposes every group boundary.

// File: rtl/ptl_pkg.sv
package ptl_pkg;

   localparam int NUM_OUT = 4;
   localparam int NUM_GRP = 4;
   localparam int BYP_W   = 4;

   typedef enum logic [1:0] {
      OM_SHARE  = 2'd0,
      OM_BYPASS = 2'd1,
      OM_XOR    = 2'd2,
      OM_SINGLE = 2'd3
   } out_mode_e;

   typedef enum logic [1:0] {
      CU_LOGIC = 2'd0,
      CU_AUX   = 2'd1,
      CU_RESET = 2'd2,
      CU_RSVD  = 2'd3
   } ctl_use_e;

endpackage

// File: rtl/ptl_term_array.sv
module ptl_term_array #(
   parameter int NI = 18,
   parameter int NT = 20
) (
   input  logic [NI-1:0]    lit_in,
   input  logic [NT*NI-1:0] true_mask,
   input  logic [NT*NI-1:0] comp_mask,
   input  logic [NT-1:0]    term_en,
   output logic [NT-1:0]    pt
);

   initial begin
      assert (NI > 0 && NT > 0) else $error("term array: empty geometry");
   end

   for (genvar t = 0; t < NT; t++) begin : g_term
      logic [NI-1:0] pass;
      assign pass  = (~true_mask[t*NI +: NI] | lit_in) &
                     (~comp_mask[t*NI +: NI] | ~lit_in);
      assign pt[t] = term_en[t] & (&pass);
   end

endmodule

// File: rtl/ptl_ctrl.sv
module ptl_ctrl #(
   parameter int NT     = 20,
   parameter int CLK_PT = 12,
   parameter int OE_PT  = 19
) (
   input  logic [NT-1:0] pt,
   input  logic [1:0]    clk_use,
   input  logic [1:0]    oe_use,
   output logic [NT-1:0] taken,
   output logic          pt_clk,
   output logic          pt_oe,
   output logic          pt_rst
);
   import ptl_pkg::*;

   initial begin
      assert (CLK_PT < NT && OE_PT < NT && CLK_PT != OE_PT)
         else $error("ctrl: control term index out of range");
   end

   logic clk_taken, oe_taken;
   assign clk_taken = (clk_use != CU_LOGIC);
   assign oe_taken  = (oe_use  != CU_LOGIC);

   always_comb begin
      taken         = '0;
      taken[CLK_PT] = clk_taken;
      taken[OE_PT]  = oe_taken;
   end

   assign pt_clk = (clk_use == CU_AUX) & pt[CLK_PT];
   assign pt_oe  = (oe_use  == CU_AUX) & pt[OE_PT];
   assign pt_rst = ((clk_use == CU_RESET) & pt[CLK_PT]) |
                   ((oe_use  == CU_RESET) & pt[OE_PT]);

endmodule

// File: rtl/ptl_share.sv
module ptl_share #(
   parameter int NT     = 20,
   parameter int GSZ0   = 4,
   parameter int GSZ1   = 4,
   parameter int GSZ2   = 5,
   parameter int GSZ3   = 7,
   parameter bit XOR_EN = 1'b1
) (
   input  logic [NT-1:0]                     pt,
   input  logic [NT-1:0]                     taken,
   input  logic [2*ptl_pkg::NUM_OUT-1:0]     out_mode,
   input  logic [ptl_pkg::NUM_OUT*ptl_pkg::NUM_GRP-1:0] grp_sel,
   output logic [ptl_pkg::NUM_OUT-1:0]       sum_out,
   output logic [ptl_pkg::NUM_OUT-1:0]       xor_b
);
   import ptl_pkg::*;

   localparam int OFF1 = GSZ0;
   localparam int OFF2 = OFF1 + GSZ1;
   localparam int OFF3 = OFF2 + GSZ2;
   localparam int TOT  = OFF3 + GSZ3;

   initial begin
      assert (TOT == NT) else $error("share: group sizes do not cover terms");
      assert (BYP_W * NUM_OUT <= NT) else $error("share: bypass span too wide");
   end

   function automatic int grp_of(input int t);
      if (t < OFF1)      return 0;
      else if (t < OFF2) return 1;
      else if (t < OFF3) return 2;
      else               return 3;
   endfunction

   logic [NT-1:0]      xtake;
   logic [NT-1:0]      live;
   logic [NUM_GRP-1:0] grp_sum;

   // terms claimed as XOR operands
   if (XOR_EN) begin : g_xor
      always_comb begin
         xtake = '0;
         for (int k = 0; k < NUM_OUT; k++)
            if (out_mode[2*k +: 2] == OM_XOR) xtake[BYP_W*k] = 1'b1;
      end
   end else begin : g_noxor
      assign xtake = '0;
   end

   assign live = pt & ~taken & ~xtake;

   always_comb begin
      grp_sum = '0;
      for (int t = 0; t < NT; t++)
         if (live[t]) grp_sum[grp_of(t)] = 1'b1;
   end

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
      logic [1:0] md;
      logic       shared;
      assign md     = out_mode[2*k +: 2];
      assign shared = |(grp_sum & grp_sel[NUM_GRP*k +: NUM_GRP]);
      always_comb begin
         unique case (md)
            OM_BYPASS: sum_out[k] = |live[BYP_W*k +: BYP_W];
            OM_SINGLE: sum_out[k] = live[BYP_W*k];
            default:   sum_out[k] = shared;
         endcase
      end
      if (XOR_EN) begin : g_xb
         assign xor_b[k] = (md == OM_XOR) & pt[BYP_W*k] & ~taken[BYP_W*k];
      end else begin : g_nxb
         assign xor_b[k] = 1'b0;
      end
   end

endmodule

// File: rtl/ptl_logic_cell.sv
module ptl_logic_cell #(
   parameter int N_BUS  = 16,
   parameter int N_DED  = 2,
   parameter int GSZ0   = 4,
   parameter int GSZ1   = 4,
   parameter int GSZ2   = 5,
   parameter int GSZ3   = 7,
   parameter int CLK_PT = 12,
   parameter int OE_PT  = 19,
   parameter bit XOR_EN = 1'b1,
   localparam int NI    = N_BUS + N_DED,
   localparam int NT    = GSZ0 + GSZ1 + GSZ2 + GSZ3
) (
   input  logic [N_BUS-1:0]   bus_in,
   input  logic [N_DED-1:0]   ded_in,
   input  logic [NT*NI-1:0]   cfg_true_mask,
   input  logic [NT*NI-1:0]   cfg_comp_mask,
   input  logic [NT-1:0]      cfg_term_en,
   input  logic [7:0]         cfg_out_mode,
   input  logic [15:0]        cfg_grp_sel,
   input  logic [1:0]         cfg_pt12_mode,
   input  logic [1:0]         cfg_pt19_mode,
   output logic [3:0]         sum_out,
   output logic [3:0]         xor_b,
   output logic               pt_clk,
   output logic               pt_rst,
   output logic               pt_oe
);
   import ptl_pkg::*;

   initial begin
      assert (NUM_OUT == 4 && NUM_GRP == 4) else $error("cell: port widths assume four outputs");
      assert (N_BUS > 0 && N_DED >= 0) else $error("cell: bad input widths");
   end

   logic [NI-1:0] lit;
   logic [NT-1:0] pt;
   logic [NT-1:0] taken;

   assign lit = {ded_in, bus_in};

   ptl_term_array #(.NI(NI), .NT(NT)) u_terms (
      .lit_in   (lit),
      .true_mask(cfg_true_mask),
      .comp_mask(cfg_comp_mask),
      .term_en  (cfg_term_en),
      .pt       (pt)
   );

   ptl_ctrl #(.NT(NT), .CLK_PT(CLK_PT), .OE_PT(OE_PT)) u_ctrl (
      .pt     (pt),
      .clk_use(cfg_pt12_mode),
      .oe_use (cfg_pt19_mode),
      .taken  (taken),
      .pt_clk (pt_clk),
      .pt_oe  (pt_oe),
      .pt_rst (pt_rst)
   );

   ptl_share #(.NT(NT), .GSZ0(GSZ0), .GSZ1(GSZ1), .GSZ2(GSZ2), .GSZ3(GSZ3),
               .XOR_EN(XOR_EN)) u_share (
      .pt      (pt),
      .taken   (taken),
      .out_mode(cfg_out_mode),
      .grp_sel (cfg_grp_sel),
      .sum_out (sum_out),
      .xor_b   (xor_b)
   );

   // checks across the sub-blocks
   always_comb begin
      for (int t = 0; t < NT; t++)
         assert_off_term_low_R2: assert (cfg_term_en[t] || !pt[t])
            else $error("R2: disabled term %0d is high", t);
      for (int k = 0; k < NUM_OUT; k++) begin
         if (cfg_out_mode[2*k +: 2] == OM_BYPASS) begin
            assert_bypass_no_xor_R5: assert (!xor_b[k])
               else $error("R5: xor operand live in bypass on output %0d", k);
            assert_bypass_quiet_R5: assert ((|pt[BYP_W*k +: BYP_W]) || !sum_out[k])
               else $error("R5: bypass output %0d high with quartet low", k);
         end
         if (cfg_out_mode[2*k +: 2] == OM_SINGLE)
            assert_single_follows_R7: assert (sum_out[k] == (pt[BYP_W*k] & ~taken[BYP_W*k]))
               else $error("R7: single output %0d mismatch", k);
         if (cfg_out_mode[2*k +: 2] == OM_SHARE && cfg_grp_sel[NUM_GRP*k +: NUM_GRP] == '0)
            assert_empty_sel_low_R4: assert (!sum_out[k])
               else $error("R4: empty selection on output %0d is high", k);
      end
      assert_clk_needs_term_R8: assert (!pt_clk || cfg_term_en[CLK_PT])
         else $error("R8: clock term high while disabled");
      assert_oe_needs_term_R9: assert (!pt_oe || cfg_term_en[OE_PT])
         else $error("R9: oe term high while disabled");
   end

endmodule

// File: tb/test_ptl_logic_cell.sv
module test_ptl_logic_cell;

   localparam int NI = 18;
   localparam int NT = 20;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [15:0]    bus_in;
   logic [1:0]     ded_in;
   logic [NT*NI-1:0] tmask, cmask;
   logic [NT-1:0]  ten;
   logic [7:0]     omode;
   logic [15:0]    gsel;
   logic [1:0]     m12, m19;
   logic [3:0]     sum_out, xor_b;
   logic           pt_clk, pt_rst, pt_oe;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   ptl_logic_cell i_ptl_logic_cell (
      .bus_in(bus_in), .ded_in(ded_in),
      .cfg_true_mask(tmask), .cfg_comp_mask(cmask), .cfg_term_en(ten),
      .cfg_out_mode(omode), .cfg_grp_sel(gsel),
      .cfg_pt12_mode(m12), .cfg_pt19_mode(m19),
      .sum_out(sum_out), .xor_b(xor_b),
      .pt_clk(pt_clk), .pt_rst(pt_rst), .pt_oe(pt_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic clear_cfg();
      @(posedge clk);
      tmask = '0; cmask = '0; ten = '0; omode = '0; gsel = '0;
      m12 = 2'd0; m19 = 2'd0; bus_in = '0; ded_in = '0;
   endtask

   function automatic int grp_of(input int t);
      if (t <= 3) return 0;
      if (t <= 7) return 1;
      if (t <= 12) return 2;
      return 3;
   endfunction

   task automatic t_reset_state();
      clear_cfg();
      bus_in = 16'hA5C3; ded_in = 2'b11;
      settle();
      chk("R2 idle sums", sum_out, 0);
      chk("R2 idle xor", xor_b, 0);
      chk("R2 idle ctl", {pt_clk, pt_rst, pt_oe}, 0);
   endtask

   task automatic t_literals();
      clear_cfg();
      ten[0] = 1'b1; tmask[0*NI + 3] = 1'b1; cmask[0*NI + 17] = 1'b1;
      gsel[0] = 1'b1;
      bus_in = 16'h0008; ded_in = 2'b00; settle();
      chk("R1 true&inv met", sum_out[0], 1);
      @(posedge clk); ded_in = 2'b10; settle();
      chk("R1 inv literal blocks", sum_out[0], 0);
      @(posedge clk); ded_in = 2'b01; bus_in = 16'h0000; settle();
      chk("R1 true literal blocks", sum_out[0], 0);
      @(posedge clk); tmask = '0; cmask = '0;
      tmask[0*NI + 5] = 1'b1; cmask[0*NI + 5] = 1'b1; bus_in = 16'h0020; settle();
      chk("R1 both polarities bus5=1", sum_out[0], 0);
      @(posedge clk); bus_in = 16'h0000; settle();
      chk("R1 both polarities bus5=0", sum_out[0], 0);
   endtask

   task automatic t_empty_term();
      clear_cfg();
      ten[1] = 1'b1; gsel[0] = 1'b1; settle();
      chk("R2 empty term is one", sum_out[0], 1);
      @(posedge clk); ten[1] = 1'b0; settle();
      chk("R2 disabled term is zero", sum_out[0], 0);
   endtask

   task automatic t_groups();
      clear_cfg();
      gsel = 16'h8421;    // output k selects group k only
      for (int t = 0; t < NT; t++) begin
         @(posedge clk); ten = '0; ten[t] = 1'b1; settle();
         chk($sformatf("R3 term %0d group", t), sum_out, 32'(1) << grp_of(t));
      end
      @(posedge clk); ten = '1; gsel = '0; settle();
      chk("R4 empty selection", sum_out, 0);
      @(posedge clk); gsel = 16'h000A; ten = '0; ten[6] = 1'b1; settle();
      chk("R4 combined g1 member", sum_out[0], 1);
      @(posedge clk); ten = '0; ten[19] = 1'b1; settle();
      chk("R4 combined g3 member", sum_out[0], 1);
      @(posedge clk); ten = '0; ten[0] = 1'b1; settle();
      chk("R4 combined excludes g0", sum_out[0], 0);
      chk("R4 xor operand idle", xor_b, 0);
   endtask

   task automatic t_bypass();
      clear_cfg();
      omode[3:2] = 2'd1; gsel[7:4] = 4'h0;
      ten[6] = 1'b1; tmask[6*NI + 2] = 1'b1; ten[4] = 1'b1; tmask[4*NI + 9] = 1'b1;
      bus_in = 16'h0004; settle();
      chk("R5 bypass follows term6", sum_out[1], 1);
      @(posedge clk); bus_in = 16'h0000; settle();
      chk("R5 bypass low", sum_out[1], 0);
      @(posedge clk); bus_in = 16'h0200; settle();
      chk("R5 bypass term4 high", sum_out[1], 1);
      chk("R5 bypass no xor operand", xor_b[1], 0);
      @(posedge clk); ten = '0; ten[8] = 1'b1; ten[0] = 1'b1; gsel[7:4] = 4'h5; settle();
      chk("R5 select ignored", sum_out[1], 0);
   endtask

   task automatic t_xor();
      clear_cfg();
      omode[5:4] = 2'd2; ten[8] = 1'b1;
      gsel[3:0] = 4'h4; gsel[11:8] = 4'h4; settle();
      chk("R6 xor operand", xor_b[2], 1);
      chk("R6 term removed from g2 (out0)", sum_out[0], 0);
      chk("R6 term removed from g2 (out2)", sum_out[2], 0);
      @(posedge clk); ten[9] = 1'b1; settle();
      chk("R6 shared sum out2", sum_out[2], 1);
      chk("R6 shared sum out0", sum_out[0], 1);
      @(posedge clk); ten[9] = 1'b0; omode[5:4] = 2'd0; settle();
      chk("R6 term returns in share", sum_out[0], 1);
      chk("R6 xor cleared in share", xor_b[2], 0);
   endtask

   task automatic t_single();
      clear_cfg();
      omode[7:6] = 2'd3; gsel[15:12] = 4'hF; ten[12] = 1'b1; settle();
      chk("R7 single term12", sum_out[3], 1);
      chk("R7 single no xor", xor_b[3], 0);
      @(posedge clk); ten = '0; ten[13] = 1'b1; settle();
      chk("R7 single ignores others", sum_out[3], 0);
   endtask

   task automatic t_ctl12();
      clear_cfg();
      ten[12] = 1'b1; gsel[3:0] = 4'h4; omode[7:6] = 2'd1; settle();
      chk("R8 logic use", {sum_out[3], sum_out[0], pt_clk, pt_rst}, 4'b1100);
      @(posedge clk); m12 = 2'd1; settle();
      chk("R8 clock use", {sum_out[3], sum_out[0], pt_clk, pt_rst}, 4'b0010);
      @(posedge clk); m12 = 2'd2; settle();
      chk("R8 reset use", {sum_out[3], sum_out[0], pt_clk, pt_rst}, 4'b0001);
   endtask

   task automatic t_ctl19();
      clear_cfg();
      ten[19] = 1'b1; gsel[3:0] = 4'h8; settle();
      chk("R9 logic use", {sum_out[0], pt_oe, pt_rst}, 3'b100);
      @(posedge clk); m19 = 2'd1; settle();
      chk("R9 oe use", {sum_out[0], pt_oe, pt_rst}, 3'b010);
      @(posedge clk); m19 = 2'd2; settle();
      chk("R9 reset use", {sum_out[0], pt_oe, pt_rst}, 3'b001);
      @(posedge clk); ten[19] = 1'b0; ten[12] = 1'b1; m12 = 2'd2; settle();
      chk("R9 reset OR of sources", pt_rst, 1);
   endtask

   initial begin
      t_reset_state();
      t_literals();
      t_empty_term();
      t_groups();
      t_bypass();
      t_xor();
      t_single();
      t_ctl12();
      t_ctl19();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual expired expected done");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule